// File: doc/BRIEF.md
# Receive Buffer Watermark Pause Requester

This block sits beside a receive buffer in an Ethernet MAC. It watches the buffer fill level, counted in 4-byte words, and drives a level-type pause request toward the transmit side. The request goes up once the level reaches a high watermark. It stays up until the MAC acknowledges that an XOFF frame has been sent. A retry timer then counts pause quanta. When the programmed number of quanta has passed and the level is still above the low watermark, the request goes up again. When the level sinks to or below the low watermark, the request is withdrawn and a one-cycle XON pulse is given.

A second function gates the fabric-side ready signal for each frame. Ready stays low until a programmed number of words of the current frame has been written, counted from the frame's first word. It also rises when the frame's last word is written, so that short frames never stall. Software controls both functions through an enable bit and a reset bit. The settings are plain inputs, normally driven from configuration registers. Their usual power-up values are all ones: 0x1FFF for the high mark, 0xFFFF for the retry count and 0xFFF for the store threshold.

Pause states are `P_OFF`, `P_IDLE`, `P_REQ` and `P_HOLD`. Their transitions are:
- enable (`P_OFF`→`P_IDLE`)
- raise (`P_IDLE`→`P_REQ`, when the level is at or above the high mark)
- acknowledge (`P_REQ`→`P_HOLD`, which loads the timer)
- reload (`P_HOLD`→`P_HOLD`, when an acknowledge arrives during the hold)
- retry (`P_HOLD`→`P_REQ`, when the timer expires)
- release (`P_REQ` or `P_HOLD`→`P_IDLE`, when the level is at or below the low mark; this gives the XON pulse)
- disable (any state→`P_OFF`)

Store-gate states are `G_WAIT`, `G_FILL` and `G_PASS`. Their transitions are:
- start (a write that begins a frame leaves `G_WAIT` or `G_PASS`)
- fill (`G_FILL` stays in `G_FILL` while below the threshold)
- open (to `G_PASS`, when the threshold is reached or the frame's last word is written)
- disable (any state→`G_WAIT`)

Top module: `rxbuf_pause_ctrl`

## Requirements
- R1: The block is active only while `sw_enable`=1 and `sw_reset`=0. During reset, and one cycle after the block becomes inactive, `pause_req`, `xon_pulse` and `fabric_ready` are 0, and the retry count is cleared.
- R2: In the idle state, a sampled `fill_level` >= `high_mark` raises `pause_req` on the following cycle.
- R3: A raised `pause_req` stays 1 until `pause_ack` is sampled. The cycle after `pause_ack`, `pause_req` is 0 and the hold state begins.
- R4: In the hold state, the retry timer holds `retry_quanta` and decrements on each sampled `quanta_tick`. If the level stays above `low_mark`, `pause_req` returns to 1 one cycle after the edge that samples the Nth tick, where N is `retry_quanta`. With N=0, it returns to 1 on the second cycle after the acknowledge.
- R5: A `pause_ack` sampled during the hold state reloads the timer with `retry_quanta`.
- R6: When `fill_level` <= `low_mark` is sampled while requesting or holding, the block drops `pause_req` and returns to idle. On the next cycle `xon_pulse` is 1 for exactly one cycle, and no retry follows, whatever ticks arrive.
- R7: For each frame, after the kth write counted from the write with `wr_sof`=1, `fabric_ready` is 1 when k >= `store_thresh`. A threshold of 0 behaves as 1.
- R8: The write carrying `wr_eof`=1 sets `fabric_ready` on the next cycle, whatever the threshold.
- R9: Once set, `fabric_ready` stays 1 until the next write that starts a frame.
- R10: After the block becomes active again, it passes through idle for one cycle. If the level is still at or above `high_mark`, it then raises `pause_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_enable | input | 1 | Software enable request |
| sw_reset | input | 1 | Software hold-in-reset |
| high_mark | input | 13 | High watermark, in words |
| low_mark | input | 13 | Low watermark, in words |
| retry_quanta | input | 16 | Retry interval, in pause quanta |
| store_thresh | input | 12 | Words per frame required before ready |
| fill_level | input | 13 | Current buffer fill level, in words |
| quanta_tick | input | 1 | One pulse per pause quantum |
| pause_ack | input | 1 | MAC has sent the XOFF frame |
| wr_valid | input | 1 | A frame word is written this cycle |
| wr_sof | input | 1 | The written word is the first of a frame |
| wr_eof | input | 1 | The written word is the last of a frame |
| pause_req | output | 1 | Pause request level |
| xon_pulse | output | 1 | One-cycle release indication |
| fabric_ready | output | 1 | Downstream receive ready |

## Verification
The watermark path is swept with three high marks. Each sweep rises one word at a time past the mark and then falls back below the low mark, which shows that the request latches at the high mark and releases only at the low mark. Retry timing is tried for interval lengths 0 through 4, with idle cycles placed between ticks. This tells the counting of ticks apart from the counting of cycles. Separate runs cover an acknowledge that reloads the timer mid-hold, a release during the hold followed by stray ticks, and toggling of both software controls. The store gate is swept over every threshold from 0 to 5 combined with every frame length from 1 to 6. This shows whether ready opens at the threshold or at the frame's end, whichever comes first, and whether it then stays open.

// File: rtl/rxp_pkg.sv
package rxp_pkg;

    typedef enum logic [1:0] {
        P_OFF,
        P_IDLE,
        P_REQ,
        P_HOLD
    } pause_st_e;

    typedef enum logic [1:0] {
        G_WAIT,
        G_FILL,
        G_PASS
    } gate_st_e;

endpackage

// File: rtl/rxp_quanta_timer.sv
module rxp_quanta_timer #(
    parameter int QNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             load,
    input  logic [QNT_W-1:0] load_val,
    input  logic             run,
    input  logic             tick,
    output logic             done
);

    logic [QNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (run && tick && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

    // A cleared timer reads as expired on the next cycle.
    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> done);  // R1

endmodule

// File: rtl/rxp_pause_fsm.sv
module rxp_pause_fsm
    import rxp_pkg::*;
#(
    parameter int LVL_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic [LVL_W-1:0] fill_level,
    input  logic [LVL_W-1:0] high_mark,
    input  logic [LVL_W-1:0] low_mark,
    input  logic             pause_ack,
    input  logic             timer_done,
    output logic             timer_load,
    output logic             timer_run,
    output logic             pause_req,
    output logic             xon_pulse
);

    pause_st_e st_q, st_d;
    logic      at_high, at_low, go_xon, xon_q;

    assign at_high = (fill_level >= high_mark);
    assign at_low  = (fill_level <= low_mark);

    always_comb begin
        st_d       = st_q;
        go_xon     = 1'b0;
        timer_load = 1'b0;
        if (!active) begin
            st_d = P_OFF;
        end else begin
            unique case (st_q)
                P_OFF:  st_d = P_IDLE;
                P_IDLE: if (at_high) st_d = P_REQ;
                P_REQ: begin
                    if (at_low) begin
                        st_d   = P_IDLE;
                        go_xon = 1'b1;
                    end else if (pause_ack) begin
                        st_d       = P_HOLD;
                        timer_load = 1'b1;
                    end
                end
                P_HOLD: begin
                    if (at_low) begin
                        st_d   = P_IDLE;
                        go_xon = 1'b1;
                    end else if (pause_ack) begin
                        timer_load = 1'b1;
                    end else if (timer_done) begin
                        st_d = P_REQ;
                    end
                end
                default: st_d = P_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= P_OFF;
            xon_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            xon_q <= go_xon;
        end
    end

    always_comb begin
        pause_req = (st_q == P_REQ);
        timer_run = (st_q == P_HOLD);
        xon_pulse = xon_q;
    end

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (!pause_req && !xon_pulse));  // R1
    AST_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pause_req) |-> ($past(at_high) || $past(timer_done)));  // R2
    AST_HOLD_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        (timer_run && !timer_done) |=> !pause_req);  // R4
    AST_XON_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        xon_pulse |=> !xon_pulse);  // R6

endmodule

// File: rtl/rxp_store_gate.sv
module rxp_store_gate
    import rxp_pkg::*;
#(
    parameter int THR_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic [THR_W-1:0] thresh,
    input  logic             wr_valid,
    input  logic             wr_sof,
    input  logic             wr_eof,
    output logic             ready
);

    localparam int CNT_W = THR_W + 1;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    gate_st_e         st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_nx;
    logic             reach, counting;

    always_comb begin
        if (wr_sof)               cnt_nx = CNT_W'(1);
        else if (cnt_q == CNT_MAX) cnt_nx = cnt_q;
        else                      cnt_nx = cnt_q + 1'b1;
    end

    assign reach    = (cnt_nx >= {1'b0, thresh});
    assign counting = wr_valid && (wr_sof || (st_q == G_FILL));

    always_comb begin
        st_d = st_q;
        if (!active) begin
            st_d = G_WAIT;
        end else begin
            unique case (st_q)
                G_WAIT, G_PASS: begin
                    if (wr_valid && wr_sof) st_d = (reach || wr_eof) ? G_PASS : G_FILL;
                end
                G_FILL: begin
                    if (wr_valid) st_d = (reach || wr_eof) ? G_PASS : G_FILL;
                end
                default: st_d = G_WAIT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= G_WAIT;
            cnt_q <= '0;
        end else begin
            st_q <= st_d;
            if (!active)       cnt_q <= '0;
            else if (counting) cnt_q <= cnt_nx;
        end
    end

    always_comb ready = (st_q == G_PASS);

    AST_READY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (active && ready && !(wr_valid && wr_sof)) |=> ready);  // R9
    AST_EOF_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        (active && wr_valid && wr_eof && (wr_sof || st_q == G_FILL)) |=> ready);  // R8
    AST_GATE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !ready);  // R1

endmodule

// File: rtl/rxbuf_pause_ctrl.sv
module rxbuf_pause_ctrl #(
    parameter int LVL_W = 13,
    parameter int QNT_W = 16,
    parameter int THR_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_enable,
    input  logic             sw_reset,
    input  logic [LVL_W-1:0] high_mark,
    input  logic [LVL_W-1:0] low_mark,
    input  logic [QNT_W-1:0] retry_quanta,
    input  logic [THR_W-1:0] store_thresh,
    input  logic [LVL_W-1:0] fill_level,
    input  logic             quanta_tick,
    input  logic             pause_ack,
    input  logic             wr_valid,
    input  logic             wr_sof,
    input  logic             wr_eof,
    output logic             pause_req,
    output logic             xon_pulse,
    output logic             fabric_ready
);

    logic active, t_load, t_run, t_done;

    assign active = sw_enable && !sw_reset;

    rxp_pause_fsm #(.LVL_W(LVL_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .active(active),
        .fill_level(fill_level), .high_mark(high_mark), .low_mark(low_mark),
        .pause_ack(pause_ack), .timer_done(t_done),
        .timer_load(t_load), .timer_run(t_run),
        .pause_req(pause_req), .xon_pulse(xon_pulse)
    );

    rxp_quanta_timer #(.QNT_W(QNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .clear(!active),
        .load(t_load), .load_val(retry_quanta),
        .run(t_run), .tick(quanta_tick), .done(t_done)
    );

    rxp_store_gate #(.THR_W(THR_W)) u_gate (
        .clk(clk), .rst_n(rst_n), .active(active),
        .thresh(store_thresh), .wr_valid(wr_valid),
        .wr_sof(wr_sof), .wr_eof(wr_eof), .ready(fabric_ready)
    );

endmodule

// File: tb/rxbuf_pause_ctrl_bench.sv
module rxbuf_pause_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n, sw_enable, sw_reset;
    logic [12:0] high_mark, low_mark, fill_level;
    logic [15:0] retry_quanta;
    logic [11:0] store_thresh;
    logic        quanta_tick, pause_ack, wr_valid, wr_sof, wr_eof;
    logic        pause_req, xon_pulse, fabric_ready;

    int total = 0;
    int bad   = 0;
    bit ended = 1'b0;

    always #10 clk = ~clk;

    rxbuf_pause_ctrl u_rxbuf_pause_ctrl (
        .clk(clk), .rst_n(rst_n), .sw_enable(sw_enable), .sw_reset(sw_reset),
        .high_mark(high_mark), .low_mark(low_mark), .retry_quanta(retry_quanta),
        .store_thresh(store_thresh), .fill_level(fill_level),
        .quanta_tick(quanta_tick), .pause_ack(pause_ack),
        .wr_valid(wr_valid), .wr_sof(wr_sof), .wr_eof(wr_eof),
        .pause_req(pause_req), .xon_pulse(xon_pulse), .fabric_ready(fabric_ready)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic tick_once();
        quanta_tick = 1'b1;
        step();
        quanta_tick = 1'b0;
    endtask

    task automatic ack_once();
        pause_ack = 1'b1;
        step();
        pause_ack = 1'b0;
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic exp_req, exp_x;
        rst_n = 1'b0; sw_enable = 1'b1; sw_reset = 1'b0;
        high_mark = 13'd8; low_mark = 13'd2; fill_level = '0;
        retry_quanta = 16'd3; store_thresh = 12'd4;
        quanta_tick = 1'b0; pause_ack = 1'b0;
        wr_valid = 1'b0; wr_sof = 1'b0; wr_eof = 1'b0;
        repeat (3) step();
        chk("R1 reset pause_req", pause_req, 1'b0);
        chk("R1 reset xon_pulse", xon_pulse, 1'b0);
        chk("R1 reset fabric_ready", fabric_ready, 1'b0);
        rst_n = 1'b1;
        step();

        // R2 R3 R6: rising and falling level sweeps
        low_mark = 13'd1;
        for (int h = 3; h <= 9; h += 3) begin
            high_mark = 13'(h);
            fill_level = '0;
            step();
            exp_req = 1'b0;
            for (int f = 0; f <= h + 2; f++) begin
                fill_level = 13'(f);
                step();
                if (f >= h) exp_req = 1'b1;
                chk("R2 rise sweep req", pause_req, exp_req);
                chk("R3 rise sweep no xon", xon_pulse, 1'b0);
            end
            for (int f = h + 2; f >= 0; f--) begin
                fill_level = 13'(f);
                step();
                exp_x = 1'b0;
                if (exp_req && f <= 1) begin
                    exp_req = 1'b0;
                    exp_x = 1'b1;
                end
                chk("R3 held until low", pause_req, exp_req);
                chk("R6 xon on release", xon_pulse, exp_x);
            end
        end

        // R4: retry after N ticks, idle cycles between ticks
        high_mark = 13'd6; low_mark = 13'd2;
        for (int n = 0; n <= 4; n++) begin
            retry_quanta = 16'(n);
            fill_level = 13'd7;
            step();
            chk("R2 raise before retry", pause_req, 1'b1);
            ack_once();
            chk("R3 ack drops req", pause_req, 1'b0);
            for (int i = 0; i < n; i++) begin
                step();
                chk("R4 waiting no tick", pause_req, 1'b0);
                tick_once();
                chk("R4 waiting after tick", pause_req, 1'b0);
            end
            step();
            chk("R4 retry after quanta", pause_req, 1'b1);
            fill_level = '0;
            step();
            chk("R6 xon from req", xon_pulse, 1'b1);
            step();
            chk("R6 xon single", xon_pulse, 1'b0);
        end

        // R6: release during hold, stray ticks ignored
        retry_quanta = 16'd2;
        fill_level = 13'd7;
        step();
        ack_once();
        fill_level = 13'd1;
        step();
        chk("R6 hold release req", pause_req, 1'b0);
        chk("R6 hold release xon", xon_pulse, 1'b1);
        fill_level = 13'd4;
        for (int i = 0; i < 6; i++) begin
            tick_once();
            chk("R6 no retry after release", pause_req, 1'b0);
        end

        // R5: acknowledge in hold reloads the timer
        retry_quanta = 16'd3;
        fill_level = 13'd7;
        step();
        ack_once();
        tick_once();
        tick_once();
        ack_once();
        chk("R5 reload ack", pause_req, 1'b0);
        tick_once();
        tick_once();
        chk("R5 reload still waiting", pause_req, 1'b0);
        tick_once();
        chk("R5 reload last tick", pause_req, 1'b0);
        step();
        chk("R5 retry after reload", pause_req, 1'b1);

        // R1 R10: software controls
        sw_enable = 1'b0;
        step();
        chk("R1 disable drops req", pause_req, 1'b0);
        step();
        chk("R1 disabled stays low", pause_req, 1'b0);
        sw_enable = 1'b1;
        step();
        chk("R10 reenable idle cycle", pause_req, 1'b0);
        step();
        chk("R10 reenable raises", pause_req, 1'b1);
        sw_reset = 1'b1;
        step();
        chk("R1 sw_reset drops req", pause_req, 1'b0);
        chk("R1 sw_reset no xon", xon_pulse, 1'b0);
        sw_reset = 1'b0;
        step();
        chk("R10 after sw_reset idle", pause_req, 1'b0);
        step();
        chk("R10 after sw_reset raises", pause_req, 1'b1);
        fill_level = '0;
        step();
        step();

        // R7 R8 R9: store gate sweep
        for (int t = 0; t <= 5; t++) begin
            for (int len = 1; len <= 6; len++) begin
                store_thresh = 12'(t);
                for (int k = 1; k <= len; k++) begin
                    wr_valid = 1'b1;
                    wr_sof = (k == 1);
                    wr_eof = (k == len);
                    step();
                    if (k == len) chk("R8 ready at eof", fabric_ready, 1'b1);
                    else          chk("R7 ready vs threshold", fabric_ready, (k >= t));
                end
                wr_valid = 1'b0; wr_sof = 1'b0; wr_eof = 1'b0;
                step();
                chk("R9 ready stays after frame", fabric_ready, 1'b1);
            end
        end
        sw_enable = 1'b0;
        step();
        chk("R1 disable drops ready", fabric_ready, 1'b0);

        finish_run();
    end

endmodule